// File: doc/BRIEF.md
# Pointer-Addressed Open-Drain Bit Port

This block holds the output latches of a six-pin open-drain I/O port. Software does not reach it as a parallel register. A 4-bit index selects one pin, and four single-cycle commands act on the latches: raise one latch, lower one latch, raise every latch, and probe one pin. The probe returns a registered skip flag, which the sequencer uses to step over its next operation. A latch at 0 turns on the pad's low-side driver. A latch at 1 lets the pin float, and the pin is then read back through a two-flop synchronizer.

Two of the pins, index 2 and index 3, are shared with latches that belong to other ports. Each shared pin is pulled low when either its own latch or the partner latch is 0. Both shared pins also have a pull-up enable and a wake enable. When a wake-enabled shared pin is seen low after synchronization, the block raises a wake request. Commands use a plain strobe with no back-pressure: the block accepts one command on every clock in which the strobe is high.

Top module: `bitport_ctrl`

## Requirements
- R1: After reset, every latch is 1. `pad_oe` is 0, and `skip_out`, `wake_req`, `pullup_en` and the wake enables are all 0.
- R2: With `cmd_valid` high, `cmd_op`=2'b00 (set) and `ptr_y` below 6, latch `ptr_y` becomes 1. From the next clock, `pad_oe[ptr_y]` is 0 for an unshared pin, and the other latches are unchanged.
- R3: With `cmd_valid` high, `cmd_op`=2'b01 (reset) and `ptr_y` below 6, latch `ptr_y` becomes 0. From the next clock, `pad_oe[ptr_y]` is 1, and the other latches are unchanged.
- R4: `cmd_op`=2'b10 (clear-all) sets all six latches to 1, whatever the value of `ptr_y`.
- R5: A set or reset with `ptr_y` of 6 or more changes no latch.
- R6: `cmd_op`=2'b11 (test) makes `skip_out` high in the following cycle exactly when the synchronized level of pin `ptr_y` is 0. A test with `ptr_y` of 6 or more gives 0. The pin level passes through two flops before it is compared.
- R7: `skip_out` is high for one cycle only, and it is 0 in any cycle that does not directly follow a test.
- R8: `pad_oe[2]` is 1 when latch 2 is 0 or `alt2_latch` is 0. `pad_oe[3]` is 1 when latch 3 is 0 or `alt3_latch` is 0.
- R9: A clock with `cfg_we` high loads `pullup_en` from `cfg_pullup` and loads the wake enables from `cfg_wake` (bit 0 = pin 2, bit 1 = pin 3). With `cfg_we` low, these enables hold their values.
- R10: `wake_req` is a register. It is 1 when an enabled shared pin was low after synchronization, and 0 while no low pin is enabled.
- R11: With `cmd_valid` low, no latch changes and `skip_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 set, 01 reset, 10 clear-all, 11 test |
| ptr_y | input | 4 | Pin index |
| pad_in | input | 6 | Pin levels as seen at the pads |
| alt2_latch | input | 1 | Partner latch sharing pin 2 |
| alt3_latch | input | 1 | Partner latch sharing pin 3 |
| cfg_we | input | 1 | Load strobe for pull-up and wake enables |
| cfg_pullup | input | 2 | New pull-up enables (bit 0 pin 2, bit 1 pin 3) |
| cfg_wake | input | 2 | New wake enables (bit 0 pin 2, bit 1 pin 3) |
| pad_oe | output | 6 | Low-side drive enable per pin; the pin is pulled low when 1 |
| pullup_en | output | 2 | Pull-up enables for pins 2 and 3 |
| skip_out | output | 1 | Registered result of the test command |
| wake_req | output | 1 | Wake request |

## Verification
A corrupted latch shows up on `pad_oe` on the clock edge right after the command that wrote it, and it stays visible until another command rewrites that bit. The checks therefore read the drive pattern one cycle after every command, so they also catch a wrong neighbour bit or a write to an index that should have been ignored. A fault in the read path appears on `skip_out` one cycle after a test, but only once the pin level has settled through the two synchronizer flops. For that reason each probe is preceded by three quiet cycles. A stale wake enable or a stale synchronizer shows up on `wake_req` within three clocks of the change at the pad.

// File: rtl/bitport_pkg.sv
package bitport_pkg;
  typedef enum logic [1:0] {
    OP_SET = 2'b00,
    OP_RST = 2'b01,
    OP_CLR = 2'b10,
    OP_TST = 2'b11
  } bp_op_e;
endpackage

// File: rtl/bitport_sync.sv
module bitport_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[s] <= '1;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/bitport_latch.sv
module bitport_latch
  import bitport_pkg::*;
#(
  parameter int NPINS = 6,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  bp_op_e           cmd_op,
  input  logic [PTR_W-1:0] ptr,
  input  logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] latch_q,
  output logic             skip_q
);
  localparam int IDX_W = $clog2(NPINS);

  logic [NPINS-1:0] sel;
  logic             ptr_ok;
  logic             sel_level;

  for (genvar i = 0; i < NPINS; i++) begin : g_dec
    assign sel[i] = (ptr == PTR_W'(i));
  end

  assign ptr_ok    = |sel;
  assign sel_level = |(pin_sync & sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '1;
      skip_q  <= 1'b0;
    end else begin
      skip_q <= cmd_valid && (cmd_op == OP_TST) && ptr_ok && !sel_level;
      if (cmd_valid) begin
        unique case (cmd_op)
          OP_SET:  latch_q <= latch_q | sel;
          OP_RST:  latch_q <= latch_q & ~sel;
          OP_CLR:  latch_q <= '1;
          default: latch_q <= latch_q;
        endcase
      end
    end
  end

  assert_set_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SET && ptr < PTR_W'(NPINS))
      |=> latch_q[$past(ptr[IDX_W-1:0])] == 1'b1);

  assert_reset_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RST && ptr < PTR_W'(NPINS))
      |=> latch_q[$past(ptr[IDX_W-1:0])] == 1'b0);

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_CLR) |=> (&latch_q));

  assert_bad_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_SET || cmd_op == OP_RST) && ptr >= PTR_W'(NPINS))
      |=> $stable(latch_q));

  assert_skip_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == OP_TST) |=> !skip_q);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(latch_q));
endmodule

// File: rtl/bitport_cfg.sv
module bitport_cfg #(
  parameter int NALT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [NALT-1:0] pu_d,
  input  logic [NALT-1:0] wk_d,
  input  logic [NALT-1:0] alt_sync,
  output logic [NALT-1:0] pu_q,
  output logic [NALT-1:0] wk_q,
  output logic            wake_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pu_q   <= '0;
      wk_q   <= '0;
      wake_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        pu_q <= pu_d;
        wk_q <= wk_d;
      end
      wake_q <= |(wk_q & ~alt_sync);
    end
  end

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(pu_q) && $stable(wk_q)));

  assert_wake_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_q == '0) |=> !wake_q);
endmodule

// File: rtl/bitport_ctrl.sv
module bitport_ctrl
  import bitport_pkg::*;
#(
  parameter int NPINS   = 6,
  parameter int PTR_W   = 4,
  parameter int SYNC_N  = 2,
  parameter int SHARE_A = 2,
  parameter int SHARE_B = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [PTR_W-1:0] ptr_y,
  input  logic [NPINS-1:0] pad_in,
  input  logic             alt2_latch,
  input  logic             alt3_latch,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_pullup,
  input  logic [1:0]       cfg_wake,
  output logic [NPINS-1:0] pad_oe,
  output logic [1:0]       pullup_en,
  output logic             skip_out,
  output logic             wake_req
);
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] latch_q;
  logic [1:0]       wake_en;
  logic [1:0]       shared_lvl;

  bitport_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  bitport_latch #(.NPINS(NPINS), .PTR_W(PTR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_op(bp_op_e'(cmd_op)), .ptr(ptr_y), .pin_sync(pin_sync),
    .latch_q(latch_q), .skip_q(skip_out)
  );

  assign shared_lvl = {pin_sync[SHARE_B], pin_sync[SHARE_A]};

  bitport_cfg #(.NALT(2)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .pu_d(cfg_pullup),
    .wk_d(cfg_wake), .alt_sync(shared_lvl), .pu_q(pullup_en),
    .wk_q(wake_en), .wake_q(wake_req)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_oe
    if (i == SHARE_A) begin : g_sa
      assign pad_oe[i] = ~(latch_q[i] & alt2_latch);
    end else if (i == SHARE_B) begin : g_sb
      assign pad_oe[i] = ~(latch_q[i] & alt3_latch);
    end else begin : g_own
      assign pad_oe[i] = ~latch_q[i];
    end
  end

  assert_shared_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt2_latch || !alt3_latch) |-> (pad_oe[SHARE_A] || alt2_latch) && (pad_oe[SHARE_B] || alt3_latch));
endmodule

// File: tb/sim_bitport_ctrl.sv
module sim_bitport_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic [3:0] ptr_y;
  logic [5:0] ext;
  logic [5:0] pad_in;
  logic       alt2_latch, alt3_latch;
  logic       cfg_we;
  logic [1:0] cfg_pullup, cfg_wake;
  logic [5:0] pad_oe;
  logic [1:0] pullup_en;
  logic       skip_out, wake_req;

  int vectors = 0;
  int misses  = 0;

  always #5 clk = ~clk;

  assign pad_in = ext & ~pad_oe;

  bitport_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .ptr_y(ptr_y), .pad_in(pad_in), .alt2_latch(alt2_latch),
    .alt3_latch(alt3_latch), .cfg_we(cfg_we), .cfg_pullup(cfg_pullup),
    .cfg_wake(cfg_wake), .pad_oe(pad_oe), .pullup_en(pullup_en),
    .skip_out(skip_out), .wake_req(wake_req)
  );

  typedef struct packed {
    logic [5:0] ext;
    logic       v;
    logic [1:0] op;
    logic [3:0] ptr;
    logic [5:0] oe;
    logic       sk;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{6'h3F, 1'b1, 2'b01, 4'd0,  6'h01, 1'b0},
    '{6'h3F, 1'b1, 2'b01, 4'd5,  6'h21, 1'b0},
    '{6'h3F, 1'b1, 2'b00, 4'd0,  6'h20, 1'b0},
    '{6'h3F, 1'b1, 2'b01, 4'd6,  6'h20, 1'b0},
    '{6'h3F, 1'b1, 2'b01, 4'd15, 6'h20, 1'b0},
    '{6'h3F, 1'b1, 2'b11, 4'd5,  6'h20, 1'b1},
    '{6'h3F, 1'b1, 2'b11, 4'd4,  6'h20, 1'b0},
    '{6'h2F, 1'b1, 2'b11, 4'd4,  6'h20, 1'b1},
    '{6'h3F, 1'b0, 2'b01, 4'd2,  6'h20, 1'b0},
    '{6'h3F, 1'b1, 2'b01, 4'd3,  6'h28, 1'b0},
    '{6'h3F, 1'b1, 2'b10, 4'd9,  6'h00, 1'b0},
    '{6'h3F, 1'b1, 2'b00, 4'd7,  6'h00, 1'b0},
    '{6'h3E, 1'b1, 2'b11, 4'd0,  6'h00, 1'b1},
    '{6'h3E, 1'b1, 2'b11, 4'd6,  6'h00, 1'b0},
    '{6'h3F, 1'b1, 2'b01, 4'd1,  6'h02, 1'b0},
    '{6'h3F, 1'b1, 2'b01, 4'd2,  6'h06, 1'b0}
  };

  function automatic string req_of(vec_t t);
    if (!t.v) return "R11";
    if (t.op == 2'b10) return "R4";
    if (t.op == 2'b11) return "R6";
    if (t.ptr >= 4'd6) return "R5";
    return (t.op == 2'b00) ? "R2" : "R3";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic issue(input logic v, input logic [1:0] op, input logic [3:0] p);
    cmd_valid = v; cmd_op = op; ptr_y = p;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    misses++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; ptr_y = '0;
    ext = 6'h3F; alt2_latch = 1'b1; alt3_latch = 1'b1;
    cfg_we = 1'b0; cfg_pullup = '0; cfg_wake = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 oe", {2'b0, pad_oe}, 8'h00);
    check("R1 skip/wake", {6'b0, skip_out, wake_req}, 8'h00);
    check("R1 pullup", {6'b0, pullup_en}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      ext = VT[i].ext;
      idle(3);
      issue(VT[i].v, VT[i].op, VT[i].ptr);
      check(req_of(VT[i]), {2'b0, pad_oe}, {2'b0, VT[i].oe});
      check({req_of(VT[i]), " skip"}, {7'b0, skip_out}, {7'b0, VT[i].sk});
    end

    // R7: skip lasts one cycle
    ext = 6'h3F;
    issue(1'b1, 2'b01, 4'd4);
    idle(3);
    issue(1'b1, 2'b11, 4'd4);
    check("R7 first", {7'b0, skip_out}, 8'h01);
    idle(1);
    check("R7 second", {7'b0, skip_out}, 8'h00);

    // R8: shared pins wired-AND
    issue(1'b1, 2'b10, 4'd0);
    check("R8 base", {2'b0, pad_oe}, 8'h00);
    alt2_latch = 1'b0; #1;
    check("R8 pin2", {2'b0, pad_oe}, 8'h04);
    alt3_latch = 1'b0; #1;
    check("R8 pin3", {2'b0, pad_oe}, 8'h0C);
    alt2_latch = 1'b1; alt3_latch = 1'b1; #1;
    check("R8 release", {2'b0, pad_oe}, 8'h00);

    // R9: enable loading and holding
    @(negedge clk);
    cfg_we = 1'b1; cfg_pullup = 2'b10; cfg_wake = 2'b01;
    @(negedge clk);
    cfg_we = 1'b0; cfg_pullup = 2'b01; cfg_wake = 2'b10;
    check("R9 load", {6'b0, pullup_en}, 8'h02);
    idle(2);
    check("R9 hold", {6'b0, pullup_en}, 8'h02);

    // R10: wake request
    idle(3);
    check("R10 quiet", {7'b0, wake_req}, 8'h00);
    ext = 6'h3B;
    idle(4);
    check("R10 pin2 low", {7'b0, wake_req}, 8'h01);
    ext = 6'h37;
    idle(4);
    check("R10 pin3 masked", {7'b0, wake_req}, 8'h00);
    ext = 6'h3F;
    idle(4);

    // R1: mid-run reset restores latches and enables
    issue(1'b1, 2'b01, 4'd1);
    check("R1 pre", {2'b0, pad_oe}, 8'h02);
    rst_n = 1'b0;
    idle(1);
    rst_n = 1'b1;
    check("R1 after reset oe", {2'b0, pad_oe}, 8'h00);
    check("R1 after reset pu", {6'b0, pullup_en}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule